// File: doc/BRIEF.md
# Cache Sweep Invalidation Engine

This block clears, on request, every cached line whose address falls inside a window given by a lower and an upper bound. It holds the valid bits and tags of a set-associative cache as register arrays. A fill port writes a tag and marks the line valid. A lookup port reads back the valid bit and tag of any line. A one-cycle start pulse captures both bounds and launches a sweep. During the sweep a line counter visits each line once, one line per clock. The set index is the outer loop and the way is the inner loop, so the way number changes fastest.

For each visited line the engine rebuilds its address from the stored tag, the set index and zeroed offset bits. It tests that address against the captured window. A valid line inside the window loses its valid bit. While the sweep runs, `busy_o` and a stall request are both high, so surrounding logic holds off fills. One cycle after the last line is examined, `done_o` is high for a single cycle.

The controller has three named states:
- `SW_IDLE` waits for a start.
- `SW_SCAN` checks one line per cycle.
- `SW_FINISH` raises the completion pulse.

It has three transitions:
- idle→scan on an accepted start.
- scan→finish when the counter is on the last line.
- finish→idle unconditionally.

Top module: `sweep_inval_engine`

## Requirements
- R1: Out of reset `busy_o`, `done_o` and `stall_o` are low and every line reads back invalid.
- R2: A fill while idle stores the tag and marks the line valid. Both are visible on the lookup port from the next cycle.
- R3: A line's address is {tag, set index, OFF_W zero bits}. A sweep clears exactly the valid lines whose address A satisfies low ≤ A ≤ high, so both bounds are inclusive. Tags and all other lines are left unchanged.
- R4: When the low bound is greater than the high bound, a sweep clears no line.
- R5: An accepted start raises `busy_o` on the next cycle. `busy_o` then stays high for exactly SETS*WAYS cycles, one line per cycle, with the set outer and the way inner.
- R6: `done_o` is high for exactly one cycle, the cycle right after `busy_o` falls.
- R7: A start pulse during a sweep is ignored. The sweep length is unchanged, and bound inputs that change after start have no effect, because the bounds are captured when the start is accepted.
- R8: A fill presented while `busy_o` is high is discarded. The line keeps its previous tag and valid bit.
- R9: `stall_o` is high exactly when `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only in idle |
| lo_addr_i | input | TAG_W+IDX_W+OFF_W | Inclusive lower bound, captured at start |
| hi_addr_i | input | TAG_W+IDX_W+OFF_W | Inclusive upper bound, captured at start |
| fill_en_i | input | 1 | Write a line (ignored while busy) |
| fill_set_i | input | IDX_W | Set index of the fill |
| fill_way_i | input | log2(WAYS) | Way of the fill |
| fill_tag_i | input | TAG_W | Tag stored by the fill |
| look_set_i | input | IDX_W | Set index to read back |
| look_way_i | input | log2(WAYS) | Way to read back |
| look_valid_o | output | 1 | Valid bit of the selected line |
| look_tag_o | output | TAG_W | Tag of the selected line |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| stall_o | output | 1 | Stall request to the fill path |

## Verification
The bench uses the default parameters: 8-bit tags, 8 sets, 16-byte lines and 4 ways, giving 32 lines and 15-bit addresses. A sweep therefore takes 32 cycles, and the bench reads back every line after each scenario. The tags are spread so that each way occupies its own quarter of the address space. This lets windows land exactly on line addresses to test inclusive bounds, end one line short, cover half the ways, or be inverted. A fill and a second start are placed partway through a sweep, aimed at a line that is visited later, so that both can be seen to have been discarded.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    typedef enum logic [1:0] {
        SW_IDLE   = 2'd0,
        SW_SCAN   = 2'd1,
        SW_FINISH = 2'd2
    } sweep_state_e;

endpackage

// File: rtl/sweep_line_ctr.sv
module sweep_line_ctr #(
    parameter int IDX_W = 3,
    parameter int WAYS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     step_i,
    output logic [IDX_W-1:0]         set_o,
    output logic [$clog2(WAYS)-1:0]  way_o,
    output logic                     last_o
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int LIN_W = IDX_W + WAY_W;
    localparam logic [IDX_W-1:0] SET_LAST = {IDX_W{1'b1}};
    localparam logic [WAY_W-1:0] WAY_LAST = WAY_W'(WAYS - 1);

    logic [IDX_W-1:0] set_q;
    logic [WAY_W-1:0] way_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_q <= '0;
            way_q <= '0;
        end else if (clr_i) begin
            set_q <= '0;
            way_q <= '0;
        end else if (step_i) begin
            if (way_q == WAY_LAST) begin
                way_q <= '0;
                set_q <= set_q + 1'b1;
            end else begin
                way_q <= way_q + 1'b1;
            end
        end
    end

    assign set_o  = set_q;
    assign way_o  = way_q;
    assign last_o = (set_q == SET_LAST) && (way_q == WAY_LAST);

    // R5: one line per cycle, way inner, set outer
    a_r5_line_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i && !last_o) |=>
            ({set_q, way_q} == LIN_W'($past({set_q, way_q}) + 1'b1)));

    a_r5_clear_start: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (set_q == '0 && way_q == '0));

endmodule

// File: rtl/sweep_range_cmp.sv
module sweep_range_cmp #(
    parameter int TAG_W = 8,
    parameter int IDX_W = 3,
    parameter int OFF_W = 4
) (
    input  logic [TAG_W-1:0]             tag_i,
    input  logic [IDX_W-1:0]             set_i,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] lo_i,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] hi_i,
    output logic                         in_range_o
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    logic [ADDR_W-1:0] line_addr;

    always_comb begin
        line_addr  = {tag_i, set_i, {OFF_W{1'b0}}};
        in_range_o = (line_addr >= lo_i) && (line_addr <= hi_i);
    end

endmodule

// File: rtl/sweep_tag_store.sv
module sweep_tag_store #(
    parameter int TAG_W = 8,
    parameter int IDX_W = 3,
    parameter int WAYS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [IDX_W-1:0]         wr_set_i,
    input  logic [$clog2(WAYS)-1:0]  wr_way_i,
    input  logic [TAG_W-1:0]         wr_tag_i,
    input  logic                     inv_en_i,
    input  logic [IDX_W-1:0]         inv_set_i,
    input  logic [$clog2(WAYS)-1:0]  inv_way_i,
    input  logic [IDX_W-1:0]         scan_set_i,
    input  logic [$clog2(WAYS)-1:0]  scan_way_i,
    output logic                     scan_valid_o,
    output logic [TAG_W-1:0]         scan_tag_o,
    input  logic [IDX_W-1:0]         look_set_i,
    input  logic [$clog2(WAYS)-1:0]  look_way_i,
    output logic                     look_valid_o,
    output logic [TAG_W-1:0]         look_tag_o
);
    localparam int WAY_W = $clog2(WAYS);
    localparam int LIN_W = IDX_W + WAY_W;
    localparam int LINES = 1 << LIN_W;

    logic [LINES-1:0] vld_q;
    logic [TAG_W-1:0] tag_q [LINES];

    logic [LIN_W-1:0] wr_lin, inv_lin, scan_lin, look_lin;

    assign wr_lin   = {wr_set_i, wr_way_i};
    assign inv_lin  = {inv_set_i, inv_way_i};
    assign scan_lin = {scan_set_i, scan_way_i};
    assign look_lin = {look_set_i, look_way_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                vld_q[i] <= 1'b0;
                tag_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (inv_en_i && inv_lin == LIN_W'(i)) begin
                    vld_q[i] <= 1'b0;
                end else if (wr_en_i && wr_lin == LIN_W'(i)) begin
                    vld_q[i] <= 1'b1;
                end
                if (wr_en_i && wr_lin == LIN_W'(i)) begin
                    tag_q[i] <= wr_tag_i;
                end
            end
        end
    end

    assign scan_valid_o = vld_q[scan_lin];
    assign scan_tag_o   = tag_q[scan_lin];
    assign look_valid_o = vld_q[look_lin];
    assign look_tag_o   = tag_q[look_lin];

    // R3: an invalidated line reads back invalid on the next cycle
    a_r3_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en_i |=> !vld_q[$past(inv_lin)]);

    // R2: a fill sets the valid bit and stores the tag
    a_r2_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !(inv_en_i && inv_lin == wr_lin)) |=>
            (vld_q[$past(wr_lin)] && tag_q[$past(wr_lin)] == $past(wr_tag_i)));

endmodule

// File: rtl/sweep_inval_engine.sv
module sweep_inval_engine
    import sweep_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int IDX_W = 3,
    parameter int OFF_W = 4,
    parameter int WAYS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]  lo_addr_i,
    input  logic [TAG_W+IDX_W+OFF_W-1:0]  hi_addr_i,
    input  logic                          fill_en_i,
    input  logic [IDX_W-1:0]              fill_set_i,
    input  logic [$clog2(WAYS)-1:0]       fill_way_i,
    input  logic [TAG_W-1:0]              fill_tag_i,
    input  logic [IDX_W-1:0]              look_set_i,
    input  logic [$clog2(WAYS)-1:0]       look_way_i,
    output logic                          look_valid_o,
    output logic [TAG_W-1:0]              look_tag_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic                          stall_o
);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    sweep_state_e state_q, state_d;

    logic [ADDR_W-1:0] lo_q, hi_q;
    logic              accept;
    logic              scanning;
    logic              last_line;
    logic [IDX_W-1:0]  scan_set;
    logic [WAY_W-1:0]  scan_way;
    logic              scan_valid;
    logic [TAG_W-1:0]  scan_tag;
    logic              scan_in_range;
    logic              inv_en;
    logic              fill_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SW_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SW_IDLE:   if (start_i)   state_d = SW_SCAN;
            SW_SCAN:   if (last_line) state_d = SW_FINISH;
            SW_FINISH: state_d = SW_IDLE;
            default:   state_d = SW_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        accept   = 1'b0;
        scanning = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            SW_IDLE:   accept = start_i;
            SW_SCAN: begin
                scanning = 1'b1;
                busy_o   = 1'b1;
            end
            SW_FINISH: done_o = 1'b1;
            default: ;
        endcase
        stall_o = busy_o;
    end

    // bounds captured on an accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (accept) begin
            lo_q <= lo_addr_i;
            hi_q <= hi_addr_i;
        end
    end

    sweep_line_ctr #(.IDX_W(IDX_W), .WAYS(WAYS)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (accept),
        .step_i (scanning),
        .set_o  (scan_set),
        .way_o  (scan_way),
        .last_o (last_line)
    );

    sweep_range_cmp #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_cmp (
        .tag_i      (scan_tag),
        .set_i      (scan_set),
        .lo_i       (lo_q),
        .hi_i       (hi_q),
        .in_range_o (scan_in_range)
    );

    assign inv_en  = scanning && scan_valid && scan_in_range;
    assign fill_ok = fill_en_i && !busy_o;

    sweep_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W), .WAYS(WAYS)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (fill_ok),
        .wr_set_i     (fill_set_i),
        .wr_way_i     (fill_way_i),
        .wr_tag_i     (fill_tag_i),
        .inv_en_i     (inv_en),
        .inv_set_i    (scan_set),
        .inv_way_i    (scan_way),
        .scan_set_i   (scan_set),
        .scan_way_i   (scan_way),
        .scan_valid_o (scan_valid),
        .scan_tag_o   (scan_tag),
        .look_set_i   (look_set_i),
        .look_way_i   (look_way_i),
        .look_valid_o (look_valid_o),
        .look_tag_o   (look_tag_o)
    );

    // R5: an accepted start enters the sweep on the next cycle
    a_r5_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_IDLE && start_i) |=> busy_o);

    // R7: the sweep is not cut short or restarted before the last line
    a_r7_scan_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_line) |=> (busy_o && $stable(lo_q) && $stable(hi_q)));

    // R6: done is a single-cycle pulse following the sweep
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

endmodule

// File: tb/sim_sweep_inval_engine.sv
module sim_sweep_inval_engine;
    localparam int TAG_W  = 8;
    localparam int IDX_W  = 3;
    localparam int OFF_W  = 4;
    localparam int WAYS   = 4;
    localparam int SETS   = 1 << IDX_W;
    localparam int LINES  = SETS * WAYS;
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] lo_addr_i = '0;
    logic [ADDR_W-1:0] hi_addr_i = '0;
    logic              fill_en_i = 1'b0;
    logic [IDX_W-1:0]  fill_set_i = '0;
    logic [1:0]        fill_way_i = '0;
    logic [TAG_W-1:0]  fill_tag_i = '0;
    logic [IDX_W-1:0]  look_set_i = '0;
    logic [1:0]        look_way_i = '0;
    logic              look_valid_o;
    logic [TAG_W-1:0]  look_tag_o;
    logic              busy_o, done_o, stall_o;

    int total = 0;
    int bad   = 0;

    logic             m_vld [LINES];
    logic [TAG_W-1:0] m_tag [LINES];

    always #4 clk = ~clk;

    sweep_inval_engine #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .WAYS(WAYS)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .lo_addr_i(lo_addr_i), .hi_addr_i(hi_addr_i),
        .fill_en_i(fill_en_i), .fill_set_i(fill_set_i),
        .fill_way_i(fill_way_i), .fill_tag_i(fill_tag_i),
        .look_set_i(look_set_i), .look_way_i(look_way_i),
        .look_valid_o(look_valid_o), .look_tag_o(look_tag_o),
        .busy_o(busy_o), .done_o(done_o), .stall_o(stall_o)
    );

    function automatic logic [ADDR_W-1:0] addr_of(logic [TAG_W-1:0] t, int s);
        return {t, IDX_W'(s), {OFF_W{1'b0}}};
    endfunction

    function automatic logic [TAG_W-1:0] tag_for(int s, int w, int seed);
        return TAG_W'(w * 64 + s * 3 + seed);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_lines(string req);
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                look_set_i = IDX_W'(s);
                look_way_i = 2'(w);
                #1;
                chk(req, $sformatf("valid set%0d way%0d", s, w),
                    int'(look_valid_o), int'(m_vld[s*WAYS+w]));
                if (m_vld[s*WAYS+w])
                    chk(req, $sformatf("tag set%0d way%0d", s, w),
                        int'(look_tag_o), int'(m_tag[s*WAYS+w]));
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < LINES; i++) begin
            m_vld[i] = 1'b0;
            m_tag[i] = '0;
        end
    endtask

    task automatic fill_all(int seed);
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                @(negedge clk);
                fill_en_i  = 1'b1;
                fill_set_i = IDX_W'(s);
                fill_way_i = 2'(w);
                fill_tag_i = tag_for(s, w, seed);
                m_vld[s*WAYS+w] = 1'b1;
                m_tag[s*WAYS+w] = tag_for(s, w, seed);
            end
        end
        @(negedge clk);
        fill_en_i = 1'b0;
    endtask

    // poke: mid-sweep second start with new bounds and a fill to set 7 way 3
    task automatic run_sweep(logic [ADDR_W-1:0] lo, logic [ADDR_W-1:0] hi, bit poke);
        int n;
        int stall_bad;
        @(negedge clk);
        start_i = 1'b1;
        lo_addr_i = lo;
        hi_addr_i = hi;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        stall_bad = 0;
        while (busy_o && n < 100) begin
            if (stall_o !== busy_o) stall_bad++;
            if (done_o) stall_bad++;
            n++;
            if (poke && n == 10) begin
                start_i    = 1'b1;
                lo_addr_i  = '0;
                hi_addr_i  = '1;
                fill_en_i  = 1'b1;
                fill_set_i = IDX_W'(SETS - 1);
                fill_way_i = 2'(WAYS - 1);
                fill_tag_i = 8'h01;
            end else begin
                start_i   = 1'b0;
                fill_en_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i   = 1'b0;
        fill_en_i = 1'b0;
        chk("R5", "busy cycles", n, LINES);
        chk("R9", "stall mismatches in sweep", stall_bad, 0);
        chk("R6", "done after busy", int'(done_o), 1);
        chk("R9", "stall after busy", int'(stall_o), 0);
        @(negedge clk);
        chk("R6", "done one cycle", int'(done_o), 0);
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                logic [ADDR_W-1:0] a;
                a = addr_of(m_tag[s*WAYS+w], s);
                if (m_vld[s*WAYS+w] && a >= lo && a <= hi) m_vld[s*WAYS+w] = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "done", int'(done_o), 0);
        chk("R1", "stall", int'(stall_o), 0);
        check_lines("R1");
    endtask

    task automatic t_fill();
        fill_all(0);
        check_lines("R2");
    endtask

    task automatic t_full_range();
        run_sweep('0, '1, 1'b0);
        check_lines("R3");
    endtask

    task automatic t_window_exact();
        do_reset();
        fill_all(5);
        run_sweep(addr_of(tag_for(2, 1, 5), 2), addr_of(tag_for(5, 2, 5), 5), 1'b0);
        check_lines("R3");
        chk("R3", "low bound line cleared", int'(m_vld[2*WAYS+1]), 0);
        chk("R3", "below low kept", int'(m_vld[1*WAYS+1]), 1);
        chk("R3", "high bound line cleared", int'(m_vld[5*WAYS+2]), 0);
        chk("R3", "above high kept", int'(m_vld[6*WAYS+2]), 1);
    endtask

    task automatic t_window_short();
        do_reset();
        fill_all(7);
        run_sweep(addr_of(tag_for(3, 0, 7), 3) + 1, addr_of(tag_for(6, 0, 7), 6) - 1, 1'b0);
        check_lines("R3");
    endtask

    task automatic t_inverted();
        do_reset();
        fill_all(9);
        run_sweep(ADDR_W'(16'h4000), ADDR_W'(16'h1000), 1'b0);
        check_lines("R4");
    endtask

    task automatic t_busy_poke();
        do_reset();
        fill_all(2);
        run_sweep('0, ADDR_W'(16'h3FFF), 1'b1);
        check_lines("R7");
        look_set_i = IDX_W'(SETS - 1);
        look_way_i = 2'(WAYS - 1);
        #1;
        chk("R8", "fill in sweep valid", int'(look_valid_o), 1);
        chk("R8", "fill in sweep tag", int'(look_tag_o), int'(tag_for(SETS - 1, WAYS - 1, 2)));
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL R5 watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_full_range();
        t_window_exact();
        t_window_short();
        t_inverted();
        t_busy_poke();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule